// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a station-management master. It runs one register transaction at a time against an external PHY over a two-wire serial management link: a clock it generates (MDC) and a shared bidirectional data line (MDIO). The caller pulses `req_start` together with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. `busy` then stays high until the frame is over. A one-cycle `done` pulse closes the transaction. For reads, `done` comes with the captured data and an error flag.

MDC is the system clock divided by `MDC_DIV`. The default of 20 gives 2.5 MHz from a 50 MHz clock. The block changes MDIO on the falling MDC edge and samples it on the rising edge. MDIO leaves the block as a data bit plus an output enable, which together drive an external tri-state pad. Every frame is 64 MDC periods long, counted as bits 0 to 63.

Top module: `mdio_master`

## Requirements
- R1: Every frame starts with 32 driven 1 bits (bits 0 to 31), followed by the start pattern 0 then 1 (bits 32 and 33).
- R2: While busy, MDC has a period of exactly `MDC_DIV` system clocks, with equal high and low halves. MDC is low while idle. MDIO changes only on falling MDC edges and is sampled on rising edges.
- R3: Bits 34 and 35 carry the opcode: 0,1 for a write and 1,0 for a read.
- R4: Bits 36 to 40 carry the PHY address and bits 41 to 45 carry the register address, each most significant bit first.
- R5: On a write, the block drives the turnaround 1,0 in bits 46 and 47, then the 16 write-data bits MSB first in bits 48 to 63. MDIO is driven for all 64 bits.
- R6: Once a frame ends, `mdio_oe` is low and stays low until the next accepted request.
- R7: On a read, the block drives bits 0 to 45 and releases MDIO (`mdio_oe` low) from bit 46 to the end of the frame.
- R8: On a read, the block samples bit 47 and expects 0 from the PHY. If it reads 1, `err` is high in the same cycle as `done`. Otherwise `err` stays low.
- R9: On a read, the block samples bits 48 to 63 as data, MSB first, and presents them on `rd_data` in the `done` cycle.
- R10: `done` is a single-cycle pulse. `busy` is low in the `done` cycle.
- R11: A `req_start` seen while `busy` is high is ignored. It neither changes the frame in progress nor starts another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request pulse, taken only while idle |
| req_write | input | 1 | 1 selects a write, 0 a read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Read turnaround not driven to 0 (valid with done) |
| rd_data | output | 16 | Read data, updated at the end of a read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable for the pad |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
Rejecting a request while busy and finishing a frame can meet in the same cycle. The frame ends on the falling MDC edge after bit 63, and that clock edge is also the last one at which `busy` is still high. To provoke this, the bench holds `req_start` high with different fields from mid-frame through the very edge that raises `done`, and drops it only once `done` is seen. The case passes if exactly one frame was emitted, `busy` is low after `done`, and MDC and the output enable stay quiet afterwards. Around this case, the bench sweeps all 32 PHY addresses for both reads and writes and checks each captured frame bit by bit against a frame it builds itself.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int MDC_DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF = MDC_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [5:0] TA_BIT   = 6'd46;
  localparam logic [5:0] SYNC_BIT = 6'd47;
  localparam logic [5:0] LAST_BIT = 6'd63;

  logic [CW-1:0] cnt;
  logic [5:0]    bitn;
  logic [63:0]   sh;
  logic [15:0]   rsh;
  logic          wr_r, ta_bad;
  wire           tick = (cnt == CW'(HALF - 1));

  assign mdio_o  = sh[63];
  assign mdio_oe = busy && (wr_r || bitn < TA_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0; rd_data <= '0;
      mdc <= 1'b0; cnt <= '0; bitn <= '0; sh <= '0; rsh <= '0;
      wr_r <= 1'b0; ta_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (req_start) begin
          busy   <= 1'b1;
          wr_r   <= req_write;
          sh     <= {32'hFFFF_FFFF, 2'b01, (req_write ? 2'b01 : 2'b10),
                     req_phy, req_reg, 2'b10, req_wdata};
          bitn   <= '0;
          cnt    <= '0;
          mdc    <= 1'b0;
          ta_bad <= 1'b0;
        end
      end else if (!tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        mdc <= ~mdc;
        if (!mdc) begin
          if (!wr_r && bitn == SYNC_BIT) ta_bad <= mdio_i;
          if (!wr_r && bitn > SYNC_BIT)  rsh <= {rsh[14:0], mdio_i};
        end else if (bitn == LAST_BIT) begin
          busy <= 1'b0;
          done <= 1'b1;
          err  <= !wr_r && ta_bad;
          if (!wr_r) rd_data <= rsh;
        end else begin
          bitn <= bitn + 1'b1;
          sh   <= {sh[62:0], 1'b0};
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                  // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));                                 // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);                                                    // R8
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);                                                  // R2
  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wr_r));                         // R11
  AST_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mdio_oe);                                               // R6
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int DIV = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_start = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, err, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rd_data;

  int checks = 0, failures = 0, clkcnt = 0, ecount = 0, last_rise = 0, per_bad = 0;
  logic [63:0] cap_o, cap_oe;
  logic ta_drive = 1'b0;
  logic [15:0] phy_data = '0;

  always #10 clk = ~clk;
  always @(posedge clk) clkcnt++;

  mdio_master #(.MDC_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  assign mdio_i = (ecount == 47) ? ta_drive :
                  (ecount >= 48 && ecount < 64) ? phy_data[63 - ecount] : 1'b1;

  always @(posedge mdc) begin
    if (ecount < 64) begin
      cap_o[63 - ecount]  = mdio_o;
      cap_oe[63 - ecount] = mdio_oe;
    end
    if (ecount > 0 && clkcnt - last_rise != DIV) per_bad++;
    last_rise = clkcnt;
    ecount++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (clkcnt > 190000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<190000", clkcnt);
        finish_run();
      end
    end
  end

  task automatic run(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                     input logic [15:0] wd, input logic ta, input logic [15:0] pd,
                     input logic hold_start);
    logic [63:0] exp_f, exp_oe;
    exp_f  = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, wd};
    exp_oe = wr ? {64{1'b1}} : {{46{1'b1}}, 18'd0};
    @(negedge clk);
    ecount = 0; per_bad = 0; ta_drive = ta; phy_data = pd;
    req_start = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_start = 1'b0;
    if (hold_start) begin
      repeat (100) @(negedge clk);
      req_start = 1'b1; req_write = ~wr; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
    end
    while (!done) @(negedge clk);
    req_start = 1'b0;
    chk("R1 R3 R4 R5 frame bits", cap_o & exp_oe, exp_f & exp_oe);
    chk("R5 R7 drive enables", cap_oe, exp_oe);
    chk("R2 mdc period/edge count", {per_bad[31:0], ecount[31:0]}, {32'd0, 32'd64});
    chk("R8 R10 done/busy/err", {61'd0, done, busy, err}, {61'd0, 1'b1, 1'b0, !wr && ta});
    if (!wr && !ta) chk("R9 read data", {48'd0, rd_data}, {48'd0, pd});
    @(negedge clk);
    chk("R6 R10 idle after done", {61'd0, done, mdio_oe, busy}, 64'd0);
    if (hold_start) begin
      repeat (3 * DIV) @(negedge clk);
      chk("R11 request held through completion ignored",
          {61'd0, busy, mdc, mdio_oe}, 64'd0);
      chk("R11 single frame emitted", {32'd0, ecount[31:0]}, 64'd64);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 R6 R10 reset state", {59'd0, busy, done, err, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    for (int p = 0; p < 32; p++) begin
      run(1'b1, 5'(p), 5'(31 - p), 16'(p * 2053 + 17), 1'b0, 16'h0, 1'b0);
      run(1'b0, 5'(p), 5'(p ^ 5), 16'h0, 1'b0, 16'(16'hA5C3 ^ (p * 1111)), 1'b0);
    end
    run(1'b0, 5'd3, 5'd1, 16'h0, 1'b1, 16'h1234, 1'b0);
    run(1'b0, 5'd7, 5'd2, 16'h0, 1'b0, 16'hFFFF, 1'b0);
    run(1'b0, 5'd8, 5'd4, 16'h0, 1'b0, 16'h0000, 1'b0);
    run(1'b1, 5'd31, 5'd31, 16'hFFFF, 1'b0, 16'h0, 1'b1);
    run(1'b0, 5'd0, 5'd0, 16'h0, 1'b0, 16'h8001, 1'b1);
    finish_run();
  end
endmodule